// File: doc/BRIEF.md
# Six-Channel Programmable Interval Timer

This block holds six down-counting timer channels behind a small synchronous register bus. Each channel picks one of four tick-enable inputs as its time base, divides it by a power of two, and counts down from a programmed interval. When a running channel expires it raises its bit in a shared status register. Software clears that bit by writing a one to it. Each interrupt output is the channel's status bit gated by its bit in a shared interrupt enable register.

Each channel can run in periodic mode or one-shot mode. In periodic mode the counter reloads from its interval after it reaches zero and keeps running. In one-shot mode the channel stops at expiry and its enable bit reads back as zero. A reload bit in the control word copies the interval into the counter at the moment control is written. Writes to the bus take effect at the next clock edge. Reads are combinational.

Each channel is a two-state machine with the states CH_IDLE and CH_RUN. The transitions are:
- START (CH_IDLE to CH_RUN): a control write with the enable bit set.
- STOP (CH_RUN to CH_IDLE): a control write with the enable bit clear.
- FINISH (CH_RUN to CH_IDLE): a one-shot expiry.
- RESTART (CH_RUN to CH_RUN): a control write with the enable bit set.

Top module: `pit_timer_bank`

## Requirements
- R1: After reset the following hold. The interrupt enable register and the status register are 0. All intervals and counts are 0. Every channel is idle. Every control register reads 0x04 (source 1, divide by 1). All irq outputs are low.
- R2: The address map is as follows. 0x00 holds the interrupt enable bits [5:0] and 0x04 holds the status bits [5:0]. Channel n (0..5) sits at 0x10*(n+1), with control at +0, interval at +4 and live count at +8. Any other address reads 0, and writes to it change nothing.
- R3: The control bits are: bit 0 enable, bit 1 reload trigger, bits [3:2] source select, bits [6:4] prescale exponent, and bit 7 mode (1 = one-shot, 0 = periodic). Bit 1 reads back as 0. Bit 0 reads back as 1 exactly while the channel is running.
- R4: A channel receives one tick for every 2^k pulses on its selected source input, where k = control[6:4]. Every control write restarts the prescale phase, and the next tick comes on the 2^k-th selected pulse after that write.
- R5: A control write with bit 1 set loads the count from the interval register at that clock edge. A control write with bit 1 clear keeps the count.
- R6: On a tick in CH_RUN the count behaves as follows. A count above 1 decrements. A count of 1 becomes 0 and the channel expires. A count of 0 in periodic mode reloads from the interval without expiring.
- R7: At a one-shot expiry the channel returns to CH_IDLE and its count stays at 0. A one-shot channel started with count 0 expires on its first tick.
- R8: An expiry sets the channel's status bit. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an expiry and a clear land in the same cycle, the expiry wins.
- R9: irq[n] is high exactly when status bit n and enable bit n are both set. It changes in the cycle after the write to either register.
- R10: Writing a channel's count address does not change its live count. Writing its interval does not change the running count before the next reload.
- R11: A control write with bit 0 clear stops the channel. Its count holds, and it does not expire until it is started again.
- R12: If a control write and a tick for the same channel land in the same cycle, the write takes effect and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| src_tick | input | 4 | Tick-enable pulses of the four time bases |
| rdata | output | 32 | Combinational read data for addr |
| irq | output | 6 | Per-channel interrupt lines |

## Verification
The four source inputs pulse at different fixed rates: every cycle, every third cycle, every fifth cycle and every other cycle. Channels set to different sources and prescale exponents therefore reach expiry in different cycles, and a wrong divider or a wrong source decode shows up as a count that drifts from the reference. The test mixes periodic channels with one-shot channels, including a one-shot channel started at zero, to separate reload-at-zero from stop-at-expiry. Control is rewritten while the source pulses on every cycle, which exposes whether a write or a tick wins. Writes to the count address, to the status register with zero bits, and to unmapped addresses show whether state that should be untouched changes.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int CTL_W    = 8;
    localparam int EN_BIT   = 0;
    localparam int RLD_BIT  = 1;
    localparam int SRC_LSB  = 2;
    localparam int PSC_LSB  = 4;
    localparam int MODE_BIT = 7;

    localparam logic [CTL_W-1:0] CTL_TRIG_MASK = 8'h03;

    localparam logic [7:0] OFS_IEN = 8'h00;
    localparam logic [7:0] OFS_STS = 8'h04;
    localparam logic [3:0] SUB_CTL = 4'h0;
    localparam logic [3:0] SUB_IVL = 4'h4;
    localparam logic [3:0] SUB_CNT = 4'h8;

    typedef enum logic {
        CH_IDLE,
        CH_RUN
    } ch_state_e;
endpackage

// File: rtl/pit_divider.sv
module pit_divider #(
    parameter  int SRC_N = 4,
    parameter  int PSC_W = 3,
    localparam int SEL_W = $clog2(SRC_N),
    localparam int DIV_W = (1 << PSC_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] src_tick,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [PSC_W-1:0] psc,
    input  logic             restart,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;
    logic             pulse;

    always_comb begin
        pulse = src_tick[src_sel];
        lim   = DIV_W'({DIV_W{1'b1}} >> (DIV_W - int'(psc)));
        tick  = pulse && (div_q == lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart) begin
            div_q <= '0;
        end else if (pulse) begin
            div_q <= tick ? '0 : div_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter  int               DATA_W  = 32,
    parameter  int               SRC_N   = 4,
    parameter  int               PSC_W   = 3,
    parameter  logic [CTL_W-1:0] CTL_RST = 8'h04,
    localparam int               SEL_W   = $clog2(SRC_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_tick,
    input  logic              ctl_we,
    input  logic              ivl_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [CTL_W-1:0]  ctl_rd,
    output logic [DATA_W-1:0] ivl_q,
    output logic [DATA_W-1:0] cnt_q,
    output logic              running,
    output logic              oneshot,
    output logic              expire
);
    ch_state_e        state_q, state_d;
    logic [CTL_W-1:0] ctl_q;
    logic             tick, at_one, at_zero;

    pit_divider #(.SRC_N(SRC_N), .PSC_W(PSC_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .src_sel  (ctl_q[SRC_LSB +: SEL_W]),
        .psc      (ctl_q[PSC_LSB +: PSC_W]),
        .restart  (ctl_we),
        .tick     (tick)
    );

    assign oneshot = ctl_q[MODE_BIT];
    assign running = (state_q == CH_RUN);
    assign at_one  = (cnt_q == DATA_W'(1));
    assign at_zero = (cnt_q == '0);
    assign expire  = running && !ctl_we && tick && (at_one || (at_zero && oneshot));
    assign ctl_rd  = ctl_q | CTL_W'(running);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // transitions: START, STOP, FINISH, RESTART
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (ctl_we && wdata[EN_BIT]) state_d = CH_RUN;
            CH_RUN: begin
                if (ctl_we)                state_d = wdata[EN_BIT] ? CH_RUN : CH_IDLE;
                else if (expire && oneshot) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // datapath outputs: control, interval, count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
            ivl_q <= '0;
            cnt_q <= '0;
        end else if (ctl_we) begin
            ctl_q <= wdata[CTL_W-1:0] & ~CTL_TRIG_MASK;
            if (wdata[RLD_BIT]) cnt_q <= ivl_q;
        end else begin
            if (ivl_we) ivl_q <= wdata;
            if (running && tick) begin
                if (!at_one && !at_zero) cnt_q <= cnt_q - DATA_W'(1);
                else if (at_one)         cnt_q <= '0;
                else if (!oneshot)       cnt_q <= ivl_q;
            end
        end
    end
endmodule

// File: rtl/pit_timer_bank.sv
module pit_timer_bank
    import pit_pkg::*;
#(
    parameter  int               NCH     = 6,
    parameter  int               DATA_W  = 32,
    parameter  int               ADDR_W  = 8,
    parameter  int               SRC_N   = 4,
    parameter  int               PSC_W   = 3,
    parameter  logic [CTL_W-1:0] CTL_RST = 8'h04,
    localparam int               PAGE_W  = ADDR_W - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SRC_N-1:0]  src_tick,
    output logic [DATA_W-1:0] rdata,
    output logic [NCH-1:0]    irq
);
    logic [NCH-1:0]    ien_q, sts_q, expire_v, running_v, oneshot_v, ctl_we_v, ivl_we_v;
    logic [CTL_W-1:0]  ctl_rd_a [NCH];
    logic [DATA_W-1:0] ivl_a    [NCH];
    logic [DATA_W-1:0] cnt_a    [NCH];
    logic [PAGE_W-1:0] page;
    logic [3:0]        sub;
    logic              ien_we, sts_we;

    assign page   = addr[ADDR_W-1:4];
    assign sub    = addr[3:0];
    assign ien_we = wr_en && (addr == ADDR_W'(OFS_IEN));
    assign sts_we = wr_en && (addr == ADDR_W'(OFS_STS));

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            logic sel;
            assign sel         = (page == PAGE_W'(g + 1));
            assign ctl_we_v[g] = wr_en && sel && (sub == SUB_CTL);
            assign ivl_we_v[g] = wr_en && sel && (sub == SUB_IVL);

            pit_channel #(
                .DATA_W  (DATA_W),
                .SRC_N   (SRC_N),
                .PSC_W   (PSC_W),
                .CTL_RST (CTL_RST)
            ) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .src_tick (src_tick),
                .ctl_we   (ctl_we_v[g]),
                .ivl_we   (ivl_we_v[g]),
                .wdata    (wdata),
                .ctl_rd   (ctl_rd_a[g]),
                .ivl_q    (ivl_a[g]),
                .cnt_q    (cnt_a[g]),
                .running  (running_v[g]),
                .oneshot  (oneshot_v[g]),
                .expire   (expire_v[g])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= '0;
            sts_q <= '0;
        end else begin
            if (ien_we) ien_q <= wdata[NCH-1:0];
            sts_q <= (sts_we ? (sts_q & ~wdata[NCH-1:0]) : sts_q) | expire_v;
        end
    end

    assign irq = sts_q & ien_q;

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_IEN))      rdata = DATA_W'(ien_q);
        else if (addr == ADDR_W'(OFS_STS)) rdata = DATA_W'(sts_q);
        for (int c = 0; c < NCH; c++) begin
            if (page == PAGE_W'(c + 1)) begin
                case (sub)
                    SUB_CTL: rdata = DATA_W'(ctl_rd_a[c]);
                    SUB_IVL: rdata = ivl_a[c];
                    SUB_CNT: rdata = cnt_a[c];
                    default: rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/pit_bank_checks.sv
module pit_bank_checks
    import pit_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [NCH-1:0]    wdata_lo,
    input logic [NCH-1:0]    sts_q,
    input logic [NCH-1:0]    expire_v,
    input logic [NCH-1:0]    running_v,
    input logic [NCH-1:0]    oneshot_v,
    input logic [NCH-1:0]    ctl_we_v
);
    // R8
    sts_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_q & ~$past(sts_q) & ~$past(expire_v)) == '0));

    // R8
    sts_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_STS)) |=> ((sts_q & $past(wdata_lo & ~expire_v)) == '0));

    // R7
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(expire_v & oneshot_v)) |=> ((running_v & $past(expire_v & oneshot_v)) == '0));

    // R11
    ctl_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ctl_we_v) && !wdata_lo[0]) |=> ((running_v & $past(ctl_we_v)) == '0));
endmodule

bind pit_timer_bank pit_bank_checks #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata_lo  (wdata[NCH-1:0]),
    .sts_q     (sts_q),
    .expire_v  (expire_v),
    .running_v (running_v),
    .oneshot_v (oneshot_v),
    .ctl_we_v  (ctl_we_v)
);

// File: tb/pit_timer_bank_test.sv
module pit_timer_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  src_tick = '0;
    logic [31:0] rdata;
    logic [5:0]  irq;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit done = 0;

    // behavioural reference state
    logic [7:0]  m_ctl [6];
    bit          m_run [6];
    logic [31:0] m_ivl [6];
    logic [31:0] m_cnt [6];
    int          m_div [6];
    logic [5:0]  m_ien, m_sts;

    pit_timer_bank uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .src_tick(src_tick), .rdata(rdata), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] model_rd(logic [7:0] a);
        int pg = a[7:4];
        if (a == 8'h00) return 32'(m_ien);
        if (a == 8'h04) return 32'(m_sts);
        if (pg >= 1 && pg <= 6) begin
            if (a[3:0] == 4'h0) return 32'(m_ctl[pg-1] | 8'(m_run[pg-1]));
            if (a[3:0] == 4'h4) return m_ivl[pg-1];
            if (a[3:0] == 4'h8) return m_cnt[pg-1];
        end
        return 32'h0;
    endfunction

    // reference model, advanced once per rising edge
    always @(posedge clk) begin
        logic [5:0] fire;
        bit cw, iw, pulse, tk;
        if (!rst_n) begin
            for (int c = 0; c < 6; c++) begin
                m_ctl[c] = 8'h04; m_run[c] = 0; m_ivl[c] = 0; m_cnt[c] = 0; m_div[c] = 0;
            end
            m_ien = 0; m_sts = 0;
        end else begin
            fire = '0;
            for (int c = 0; c < 6; c++) begin
                cw = wr_en && (addr == 8'(16 * (c + 1)));
                iw = wr_en && (addr == 8'(16 * (c + 1) + 4));
                pulse = src_tick[m_ctl[c][3:2]];
                tk = 0;
                if (cw) begin
                    // R12: the write wins over any tick of this cycle
                    if (wdata[1]) m_cnt[c] = m_ivl[c];
                    m_ctl[c] = wdata[7:0] & 8'hFC;
                    m_run[c] = wdata[0];
                    m_div[c] = 0;
                end else begin
                    if (pulse) begin
                        if (m_div[c] == (1 << m_ctl[c][6:4]) - 1) begin
                            tk = 1; m_div[c] = 0;
                        end else m_div[c]++;
                    end
                    if (tk && m_run[c]) begin
                        if (m_cnt[c] > 1) m_cnt[c] = m_cnt[c] - 1;
                        else if (m_cnt[c] == 1) begin
                            m_cnt[c] = 0; fire[c] = 1;
                            if (m_ctl[c][7]) m_run[c] = 0;
                        end else if (m_ctl[c][7]) begin
                            fire[c] = 1; m_run[c] = 0;
                        end else m_cnt[c] = m_ivl[c];
                    end
                    if (iw) m_ivl[c] = wdata;
                end
            end
            if (wr_en && addr == 8'h00) m_ien = wdata[5:0];
            if (wr_en && addr == 8'h04) m_sts = m_sts & ~wdata[5:0];
            m_sts = m_sts | fire;
        end
    end

    // source pulse patterns and per-cycle irq comparison
    always @(negedge clk) begin
        cyc++;
        src_tick[0] <= 1'b1;
        src_tick[1] <= (cyc % 3 == 0);
        src_tick[2] <= (cyc % 5 == 0);
        src_tick[3] <= (cyc % 2 == 0);
        if (rst_n && !done) check("R9 irq", 32'(irq), 32'(m_sts & m_ien));
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, string req);
        @(negedge clk);
        addr = a; wr_en = 1'b0;
        #1 check(req, rdata, model_rd(a));
    endtask

    task automatic sweep(string req, int cycles);
        for (int k = 0; k < cycles; k++) begin
            for (int c = 0; c < 6; c++) rd(8'(16 * (c + 1) + 8), req);
            rd(8'h04, req);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq", 32'(irq), 32'h0);
        rd(8'h00, "R1 ien"); rd(8'h04, "R1 status");
        for (int c = 0; c < 6; c++) begin
            rd(8'(16 * (c + 1)), "R1 ctrl");
            check("R1 ctrl value", rdata, 32'h04);
            rd(8'(16 * (c + 1) + 4), "R1 interval");
            rd(8'(16 * (c + 1) + 8), "R1 count");
        end
        wr(8'h00, 32'h3F);
        rd(8'h00, "R2 ien");
        // R5 R6 ch0 periodic, src0, divide 1
        wr(8'h14, 32'd5);
        wr(8'h10, 32'h03);
        rd(8'h10, "R3 ctrl readback");
        sweep("R6 periodic countdown", 4);
        // R4 ch3 source 2 divide by 2; ch1 one-shot source 1 divide by 4
        wr(8'h44, 32'd4);
        wr(8'h40, 32'h1B);
        wr(8'h24, 32'd3);
        wr(8'h20, 32'hA7);
        sweep("R4 prescaled ticks", 12);
        rd(8'h20, "R7 one-shot enable cleared");
        // R8 W1C: zeros keep, ones clear
        wr(8'h04, 32'h0);
        rd(8'h04, "R8 zero write keeps status");
        wr(8'h04, 32'h3F);
        rd(8'h04, "R8 w1c clears");
        // R7 one-shot from count 0
        wr(8'h50, 32'h81);
        rd(8'h50, "R7 start at zero");
        rd(8'h04, "R7 zero-start expiry");
        rd(8'h50, "R7 enable dropped");
        // R10 count write on running ch2 (source 3)
        wr(8'h34, 32'd1000);
        wr(8'h30, 32'h0F);
        wr(8'h38, 32'd5);
        rd(8'h38, "R10 count write ignored");
        wr(8'h34, 32'd7);
        rd(8'h38, "R10 interval write no effect on count");
        // R12 rewrite ch0 control while source 0 pulses every cycle
        wr(8'h10, 32'h01);
        rd(8'h18, "R12 write beats tick");
        // R2 unmapped addresses
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h70, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h0C, "R2 unmapped read"); rd(8'h70, "R2 unmapped read");
        rd(8'h1C, "R2 unmapped read"); rd(8'h08, "R2 unmapped read");
        for (int c = 0; c < 6; c++) rd(8'(16 * (c + 1)), "R2 no side effect");
        // R11 stop ch3 and ch0
        wr(8'h40, 32'h18);
        wr(8'h10, 32'h00);
        sweep("R11 stopped count holds", 6);
        // R4 ch5 maximum prescale, source 0
        wr(8'h64, 32'd2);
        wr(8'h60, 32'h73);
        sweep("R4 divide by 128", 60);
        rd(8'h60, "R3 ctrl max prescale");
        wr(8'h00, 32'h05);
        rd(8'h00, "R9 ien partial");
        sweep("R9 gated irq", 10);
        finish_run();
    end
endmodule